// File: doc/BRIEF.md
# Register Redirection Table

This block sits between instruction decode and the register file. A scalar instruction names its operands with 5-bit register numbers. The table can remap each of those numbers onto a 7-bit index in a 128-entry register file. For every operand it also reports whether the operand is a vector, and which element width overrides the operation's natural width.

Entries arrive through a single write port in one of two formats. The full 16-bit format names the target register explicitly and can mark the operand as scalar. The compact 8-bit format derives the target by shifting the key left by two and always marks a vector. Integer and floating-point registers have separate key spaces.

The table is held as one slot per architectural register and class, so a lookup is a direct read rather than an associative compare. Three operand lookups (destination and two sources) are served in parallel. Results are registered and appear one cycle after the lookup is presented.

Top module: `redir_table`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every operand output is zero (hit 0, index 0, vector 0, width 0), and the table holds no entries.
- R2: When `wr_compact` is 0, `wr_entry` is decoded as follows: bit 15 is the vector flag (1 vector, 0 scalar), bits 14:8 are the target index, bit 7 is the class (1 integer, 0 floating point), bits 6:5 are the width code, and bits 4:0 are the key.
- R3: When `wr_compact` is 1, only `wr_entry[7:0]` is used: bit 7 is the class, bits 6:5 are the width code and bits 4:0 are the key. The target is the key shifted left by two, and the vector flag is 1. Bits 15:8 are ignored.
- R4: The width code stored in an entry is reported unchanged on `rd_ew`. The codes mean: 00 default register width, 01 8-bit, 10 16-bit, 11 32-bit.
- R5: A lookup with no entry for its key and class gives hit 0, index equal to the key zero-extended to 7 bits, vector 0 and width code 00.
- R6: Integer and floating-point entries are separate: an entry written for one class never produces a hit for a lookup of the same key in the other class.
- R7: When the same key and class are written more than once, a lookup returns the fields of the most recent write.
- R8: The three operand ports (port p uses `lk_key[5p+4:5p]` and `lk_int[p]`) are looked up independently and in parallel in the same cycle.
- R9: Lookup results appear on the outputs one clock edge after the key is presented. A write in the same cycle as a lookup is not seen by that lookup, but it is seen by a lookup in the next cycle.
- R10: A hit on an entry whose vector flag is 0 reports hit 1 with the redirected index, vector 0 and the stored width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_compact | input | 1 | 1: entry uses the compact 8-bit format; 0: full 16-bit format |
| wr_entry | input | 16 | Entry to write |
| lk_key | input | 15 | Three 5-bit operand register numbers, port 0 in the low bits |
| lk_int | input | 3 | Per port: 1 for an integer operand, 0 for floating point |
| rd_hit | output | 3 | Per port: an entry matched |
| rd_idx | output | 21 | Per port: 7-bit redirected register index |
| rd_vec | output | 3 | Per port: operand is a vector |
| rd_ew | output | 6 | Per port: 2-bit element-width code |

## Verification
Directed cases cover the following:
- lookups before any write, to check the empty pass-through;
- one write in each format, with junk in the upper byte of a compact entry;
- a scalar-marked full entry;
- the same key looked up in the opposite class;
- back-to-back rewrites of one key;
- a lookup in the same cycle as its write.

These cases separate a wrong format decode, cross-class leakage, a lost newest write and an off-by-one latency. A long stream of random writes and three-port lookups, with keys drawn from a small range so that hits and misses mix, is compared with a bench model of the table. This exposes interference between ports and between slots.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  localparam int KEY_W_DEF   = 5;
  localparam int IDX_W_DEF   = 7;
  localparam int EW_W_DEF    = 2;
  localparam int SHIFT_DEF   = 2;
  localparam int NOPS_DEF    = 3;

  typedef enum logic [1:0] {
    EW_NATIVE = 2'b00,
    EW_BYTE   = 2'b01,
    EW_HALF   = 2'b10,
    EW_WORD   = 2'b11
  } ew_code_e;

  typedef enum logic {
    CLS_FP  = 1'b0,
    CLS_INT = 1'b1
  } reg_class_e;
endpackage

// File: rtl/rrt_decode.sv
module rrt_decode #(
  parameter int KEY_W  = rrt_pkg::KEY_W_DEF,
  parameter int IDX_W  = rrt_pkg::IDX_W_DEF,
  parameter int EW_W   = rrt_pkg::EW_W_DEF,
  parameter int SHIFT  = rrt_pkg::SHIFT_DEF,
  parameter int ENT_W  = 1 + IDX_W + 1 + EW_W + KEY_W,
  parameter int DATA_W = 1 + IDX_W + EW_W
) (
  input  logic              wr_en,
  input  logic              compact,
  input  logic [ENT_W-1:0]  entry,
  output logic              we_int,
  output logic              we_fp,
  output logic [KEY_W-1:0]  wkey,
  output logic [DATA_W-1:0] wdata
);
  localparam int EW_LO   = KEY_W;
  localparam int CLS_BIT = KEY_W + EW_W;
  localparam int IDX_LO  = CLS_BIT + 1;
  localparam int VEC_BIT = ENT_W - 1;

  logic             cls;
  logic             vec;
  logic [IDX_W-1:0] tgt;
  logic [EW_W-1:0]  ew;

  always_comb begin
    wkey = entry[KEY_W-1:0];
    ew   = entry[EW_LO +: EW_W];
    cls  = entry[CLS_BIT];
    if (compact) begin
      tgt = IDX_W'(wkey) << SHIFT;
      vec = 1'b1;
    end else begin
      tgt = entry[IDX_LO +: IDX_W];
      vec = entry[VEC_BIT];
    end
    wdata  = {vec, tgt, ew};
    we_int = wr_en & (cls == rrt_pkg::CLS_INT);
    we_fp  = wr_en & (cls == rrt_pkg::CLS_FP);
  end
endmodule

// File: rtl/rrt_bank.sv
module rrt_bank #(
  parameter int KEY_W  = rrt_pkg::KEY_W_DEF,
  parameter int DATA_W = 10,
  parameter int NRD    = rrt_pkg::NOPS_DEF,
  parameter int DEPTH  = 1 << KEY_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [KEY_W-1:0]           wkey,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NRD-1:0][KEY_W-1:0]  rkey,
  output logic [NRD-1:0]             rvalid,
  output logic [NRD-1:0][DATA_W-1:0] rdata
);
  logic [DEPTH-1:0]  valid;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) valid <= '0;
    else if (we) valid[wkey] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wkey] <= wdata;
  end

  always_comb begin
    for (int i = 0; i < NRD; i++) begin
      rvalid[i] = valid[rkey[i]];
      rdata[i]  = mem[rkey[i]];
    end
  end

  // R7
  last_write_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (valid[$past(wkey)] && mem[$past(wkey)] == $past(wdata)));

  // R7
  valid_keep_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((~valid & $past(valid)) == '0));
endmodule

// File: rtl/rrt_port.sv
module rrt_port #(
  parameter int KEY_W  = rrt_pkg::KEY_W_DEF,
  parameter int IDX_W  = rrt_pkg::IDX_W_DEF,
  parameter int EW_W   = rrt_pkg::EW_W_DEF,
  parameter int DATA_W = 1 + IDX_W + EW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [KEY_W-1:0]  key,
  input  logic              is_int,
  input  logic              int_v,
  input  logic [DATA_W-1:0] int_d,
  input  logic              fp_v,
  input  logic [DATA_W-1:0] fp_d,
  output logic              hit_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              vec_q,
  output logic [EW_W-1:0]   ew_q
);
  logic              sel_v;
  logic [DATA_W-1:0] sel_d;
  logic              primed;

  always_comb begin
    sel_v = is_int ? int_v : fp_v;
    sel_d = is_int ? int_d : fp_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      idx_q  <= '0;
      vec_q  <= 1'b0;
      ew_q   <= '0;
      primed <= 1'b0;
    end else begin
      primed <= 1'b1;
      hit_q  <= sel_v;
      if (sel_v) begin
        vec_q <= sel_d[DATA_W-1];
        idx_q <= sel_d[EW_W +: IDX_W];
        ew_q  <= sel_d[EW_W-1:0];
      end else begin
        vec_q <= 1'b0;
        idx_q <= IDX_W'(key);
        ew_q  <= '0;
      end
    end
  end

  // R5
  miss_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && !hit_q) |-> (idx_q == IDX_W'($past(key))));

  // R5
  miss_scalar_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_q |-> (!vec_q && ew_q == '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!hit_q && !vec_q && idx_q == '0 && ew_q == '0));
endmodule

// File: rtl/redir_table.sv
module redir_table #(
  parameter int KEY_W  = rrt_pkg::KEY_W_DEF,
  parameter int IDX_W  = rrt_pkg::IDX_W_DEF,
  parameter int EW_W   = rrt_pkg::EW_W_DEF,
  parameter int SHIFT  = rrt_pkg::SHIFT_DEF,
  parameter int NOPS   = rrt_pkg::NOPS_DEF,
  parameter int ENT_W  = 1 + IDX_W + 1 + EW_W + KEY_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  wr_compact,
  input  logic [ENT_W-1:0]      wr_entry,
  input  logic [NOPS*KEY_W-1:0] lk_key,
  input  logic [NOPS-1:0]       lk_int,
  output logic [NOPS-1:0]       rd_hit,
  output logic [NOPS*IDX_W-1:0] rd_idx,
  output logic [NOPS-1:0]       rd_vec,
  output logic [NOPS*EW_W-1:0]  rd_ew
);
  localparam int DATA_W = 1 + IDX_W + EW_W;
  localparam int NCLS   = 2;

  logic [NCLS-1:0]                       we_cls;
  logic [KEY_W-1:0]                      wkey;
  logic [DATA_W-1:0]                     wdata;
  logic [NOPS-1:0][KEY_W-1:0]            keys;
  logic [NCLS-1:0][NOPS-1:0]             bv;
  logic [NCLS-1:0][NOPS-1:0][DATA_W-1:0] bd;

  rrt_decode #(
    .KEY_W(KEY_W), .IDX_W(IDX_W), .EW_W(EW_W), .SHIFT(SHIFT),
    .ENT_W(ENT_W), .DATA_W(DATA_W)
  ) u_decode (
    .wr_en   (wr_en),
    .compact (wr_compact),
    .entry   (wr_entry),
    .we_int  (we_cls[1]),
    .we_fp   (we_cls[0]),
    .wkey    (wkey),
    .wdata   (wdata)
  );

  always_comb begin
    for (int p = 0; p < NOPS; p++) keys[p] = lk_key[p*KEY_W +: KEY_W];
  end

  for (genvar g = 0; g < NCLS; g++) begin : g_bank
    rrt_bank #(.KEY_W(KEY_W), .DATA_W(DATA_W), .NRD(NOPS)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .we     (we_cls[g]),
      .wkey   (wkey),
      .wdata  (wdata),
      .rkey   (keys),
      .rvalid (bv[g]),
      .rdata  (bd[g])
    );
  end

  for (genvar p = 0; p < NOPS; p++) begin : g_port
    rrt_port #(.KEY_W(KEY_W), .IDX_W(IDX_W), .EW_W(EW_W), .DATA_W(DATA_W)) u_port (
      .clk    (clk),
      .rst    (rst),
      .key    (keys[p]),
      .is_int (lk_int[p]),
      .int_v  (bv[1][p]),
      .int_d  (bd[1][p]),
      .fp_v   (bv[0][p]),
      .fp_d   (bd[0][p]),
      .hit_q  (rd_hit[p]),
      .idx_q  (rd_idx[p*IDX_W +: IDX_W]),
      .vec_q  (rd_vec[p]),
      .ew_q   (rd_ew[p*EW_W +: EW_W])
    );
  end

  // R6
  class_split_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_cls) && (wr_en == (we_cls != '0)));
endmodule

// File: tb/test_redir_table.sv
module test_redir_table;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic        wr_compact;
  logic [15:0] wr_entry;
  logic [14:0] lk_key;
  logic [2:0]  lk_int;
  logic [2:0]  rd_hit;
  logic [20:0] rd_idx;
  logic [2:0]  rd_vec;
  logic [5:0]  rd_ew;

  always #10 clk = ~clk;

  redir_table i_redir_table (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_compact(wr_compact),
    .wr_entry(wr_entry), .lk_key(lk_key), .lk_int(lk_int),
    .rd_hit(rd_hit), .rd_idx(rd_idx), .rd_vec(rd_vec), .rd_ew(rd_ew)
  );

  bit       m_v   [2][32];
  bit [6:0] m_idx [2][32];
  bit       m_vec [2][32];
  bit [1:0] m_ew  [2][32];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic [15:0] full_ent(bit vec, bit [6:0] tgt, bit cls, bit [1:0] ew, bit [4:0] key);
    return {vec, tgt, cls, ew, key};
  endfunction

  function automatic [15:0] cmp_ent(bit [7:0] junk, bit cls, bit [1:0] ew, bit [4:0] key);
    return {junk, cls, ew, key};
  endfunction

  task automatic check_port(int p, bit eh, bit [6:0] ei, bit ev, bit [1:0] ee, string req);
    checks++;
    if (rd_hit[p] !== eh || rd_idx[p*7 +: 7] !== ei || rd_vec[p] !== ev || rd_ew[p*2 +: 2] !== ee) begin
      errors++;
      $display("FAIL %s port %0d: got hit=%0b idx=%0d vec=%0b ew=%0d expected hit=%0b idx=%0d vec=%0b ew=%0d",
               req, p, rd_hit[p], rd_idx[p*7 +: 7], rd_vec[p], rd_ew[p*2 +: 2], eh, ei, ev, ee);
    end
  endtask

  task automatic step(bit we, bit cmp, bit [15:0] ent,
                      bit [4:0] k0, bit [4:0] k1, bit [4:0] k2, bit [2:0] ic, string req);
    bit [4:0] ks [3];
    bit       eh [3];
    bit [6:0] ei [3];
    bit       ev [3];
    bit [1:0] ee [3];
    ks[0] = k0; ks[1] = k1; ks[2] = k2;
    wr_en = we; wr_compact = cmp; wr_entry = ent;
    lk_int = ic;
    for (int p = 0; p < 3; p++) begin
      int c = ic[p] ? 1 : 0;
      lk_key[p*5 +: 5] = ks[p];
      eh[p] = m_v[c][ks[p]];
      ei[p] = eh[p] ? m_idx[c][ks[p]] : {2'b00, ks[p]};
      ev[p] = eh[p] ? m_vec[c][ks[p]] : 1'b0;
      ee[p] = eh[p] ? m_ew[c][ks[p]] : 2'b00;
    end
    if (we) begin
      int c = ent[7] ? 1 : 0;
      bit [4:0] k = ent[4:0];
      m_v[c][k]  = 1'b1;
      m_ew[c][k] = ent[6:5];
      if (cmp) begin
        m_idx[c][k] = {k, 2'b00};
        m_vec[c][k] = 1'b1;
      end else begin
        m_idx[c][k] = ent[14:8];
        m_vec[c][k] = ent[15];
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 3; p++) check_port(p, eh[p], ei[p], ev[p], ee[p], req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; wr_en = 0; wr_compact = 0; wr_entry = '0; lk_key = 15'h7fff; lk_int = 3'b101;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 outputs cleared under reset
    for (int p = 0; p < 3; p++) check_port(p, 0, 0, 0, 0, "R1");
    rst = 1'b0;
    // R1 empty table, R5 pass-through
    step(0, 0, 0, 5'd3, 5'd17, 5'd31, 3'b011, "R1_R5");
    step(0, 0, 0, 5'd0, 5'd5, 5'd9, 3'b100, "R5");
    // R2 full write; R9 same-cycle lookup does not see it
    step(1, 0, full_ent(1, 7'd100, 1, 2'b01, 5'd5), 5'd5, 5'd5, 5'd6, 3'b111, "R9");
    // R2 hit next cycle, R6 fp same key misses
    step(0, 0, 0, 5'd5, 5'd5, 5'd6, 3'b101, "R2_R6");
    // R10 scalar-marked fp entry
    step(1, 0, full_ent(0, 7'd77, 0, 2'b10, 5'd9), 5'd9, 5'd9, 5'd9, 3'b000, "R10");
    step(0, 0, 0, 5'd9, 5'd9, 5'd9, 3'b010, "R10_R6");
    // R3 compact with junk upper byte, R4 width 11
    step(1, 1, cmp_ent(8'hff, 1, 2'b11, 5'd31), 5'd31, 5'd0, 5'd0, 3'b100, "R3");
    step(1, 1, cmp_ent(8'ha5, 0, 2'b00, 5'd0), 5'd31, 5'd31, 5'd0, 3'b001, "R3_R4");
    step(0, 0, 0, 5'd0, 5'd31, 5'd0, 3'b011, "R3_R4");
    // R7 back-to-back rewrites of one key
    step(1, 1, cmp_ent(8'h00, 1, 2'b10, 5'd5), 5'd1, 5'd2, 5'd3, 3'b111, "R7");
    step(1, 0, full_ent(0, 7'd42, 1, 2'b11, 5'd5), 5'd5, 5'd4, 5'd5, 3'b110, "R7");
    step(0, 0, 0, 5'd5, 5'd5, 5'd5, 3'b111, "R7");
    // R8 three distinct ports
    step(0, 0, 0, 5'd9, 5'd31, 5'd12, 3'b010, "R8");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit       we  = ($urandom_range(0, 2) == 0);
      bit       cm  = $urandom_range(0, 1);
      bit [15:0] e = 16'($urandom);
      bit [4:0] k0 = 5'($urandom_range(0, 7));
      bit [4:0] k1 = 5'($urandom_range(0, 31));
      bit [4:0] k2 = 5'($urandom_range(0, 7));
      e[4:0] = 5'($urandom_range(0, 9));
      step(we, cm, e, k0, k1, k2, 3'($urandom), "R8_random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule